// File: doc/BRIEF.md
# Real-Time Clock Second Prescaler with Hourly Drift Trim

This block turns a 32768 Hz clock-enable stream into a one-second strobe for a real-time clock. It counts reference enables and emits a single-cycle pulse each time one second's worth has gone by. The strobe is free-running. No run or stop input gates it, so alarm and event logic keep a time base while the calendar is frozen.

A crystal runs slightly fast or slow. To correct for this, software programs a signed 16-bit trim value as two bytes and sets an auto-trim enable. While auto-trim is on and the calendar's minutes and seconds inputs both read zero, the second in progress lasts the nominal count plus the signed trim. A negative trim shortens that second, and the result is never allowed below one enable. The calendar drives the minutes and seconds inputs in binary. The calendar arithmetic and the interrupt logic live outside this block.

Top module: `sec_prescaler`

## Requirements
- R1: After synchronous reset, the trim value and the auto-trim enable are 0, so reads at addresses 0, 1 and 2 return 0x00, and `sec_pulse` is low.
- R2: With trim inactive, `sec_pulse` rises once every REF_HZ reference enables and lasts exactly one clock cycle when REF_HZ > 1.
- R3: The count advances only in cycles where `tick_en` is high. Idle cycles neither produce a pulse nor lose the partial count.
- R4: A write to address 0 sets trim bits 7:0, and a write to address 1 sets trim bits 15:8. Each write leaves the other byte unchanged, and each address reads back its own byte.
- R5: Address 2 is the control byte. Bit 2 is the auto-trim enable. It reads back at bit 2, and all other bits read 0.
- R6: With auto-trim on and the minutes and seconds inputs both 0, the current second lasts REF_HZ plus the trim value (two's complement) in enables.
- R7: A negative trim shortens that second by its magnitude.
- R8: If REF_HZ plus the trim is below 1, the second lasts exactly 1 enable.
- R9: No trim is applied when auto-trim is off, or when either the minutes or the seconds input is nonzero.
- R10: Address 3 reads 0x00, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One-cycle enable at the 32768 Hz reference rate |
| min_in | input | 6 | Calendar minutes, binary 0..59 |
| sec_in | input | 6 | Calendar seconds, binary 0..59 |
| wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address for reads and writes |
| wr_data | input | 8 | Write data byte |
| rd_data | output | 8 | Combinational read data at `reg_addr` |
| sec_pulse | output | 1 | One-cycle strobe at the end of each second |

## Verification
The period is measured in enables under three kinds of input:
- A dense enable stream, which checks the nominal period.
- A sparse stream with a long idle gap in the middle, which shows that the period counts enables rather than clock cycles.
- Top-of-hour seconds with positive, negative and clamping trims, which shows that the signed addition and the lower bound are both correct.

The same trim is then applied with auto-trim off, with only the minutes nonzero, and with only the seconds nonzero. Each case must give the nominal period, so every condition of the gate is tested on its own. Byte writes interleaved with read-back of the other byte separate the two halves of the trim register.

// File: rtl/rtc_presc_pkg.sv
package rtc_presc_pkg;

    typedef enum logic [1:0] {
        ADDR_TRIM_LO = 2'd0,
        ADDR_TRIM_HI = 2'd1,
        ADDR_CTRL    = 2'd2,
        ADDR_UNUSED  = 2'd3
    } presc_addr_e;

    localparam int CTRL_AUTO_BIT = 2;
    localparam int TRIM_W        = 16;

    typedef struct packed {
        logic signed [TRIM_W-1:0] trim;
        logic                     auto_en;
    } presc_cfg_t;

    function automatic logic top_of_hour(input logic [5:0] mins, input logic [5:0] secs);
        return (mins == 6'd0) && (secs == 6'd0);
    endfunction

endpackage

// File: rtl/presc_regs.sv
module presc_regs
    import rtc_presc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [1:0] reg_addr,
    input  logic [7:0] wr_data,
    output presc_cfg_t cfg,
    output logic [7:0] rd_data
);
    presc_addr_e sel;
    assign sel = presc_addr_e'(reg_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (wr_en) begin
            case (sel)
                ADDR_TRIM_LO: cfg.trim[7:0]  <= wr_data;
                ADDR_TRIM_HI: cfg.trim[15:8] <= wr_data;
                ADDR_CTRL:    cfg.auto_en    <= wr_data[CTRL_AUTO_BIT];
                default:      ;
            endcase
        end
    end

    always_comb begin
        rd_data = 8'h00;
        case (sel)
            ADDR_TRIM_LO: rd_data = cfg.trim[7:0];
            ADDR_TRIM_HI: rd_data = cfg.trim[15:8];
            ADDR_CTRL:    rd_data[CTRL_AUTO_BIT] = cfg.auto_en;
            default:      rd_data = 8'h00;
        endcase
    end
endmodule

// File: rtl/presc_len.sv
module presc_len
    import rtc_presc_pkg::*;
#(
    parameter int REF_HZ = 32768,
    parameter int LEN_W  = 17
) (
    input  presc_cfg_t       cfg,
    input  logic [5:0]       min_in,
    input  logic [5:0]       sec_in,
    output logic [LEN_W-1:0] len
);
    localparam int EXT_W = LEN_W + 1 - TRIM_W;
    localparam logic [LEN_W-1:0] REF_L = LEN_W'(REF_HZ);

    logic                    apply;
    logic signed [LEN_W:0]   trim_ext;
    logic signed [LEN_W:0]   raw;

    assign apply    = cfg.auto_en && top_of_hour(min_in, sec_in);
    assign trim_ext = apply ? $signed({{EXT_W{cfg.trim[TRIM_W-1]}}, cfg.trim}) : '0;
    assign raw      = $signed({1'b0, REF_L}) + trim_ext;

    always_comb begin
        if (raw < $signed((LEN_W+1)'(1)))
            len = LEN_W'(1);
        else
            len = raw[LEN_W-1:0];
    end
endmodule

// File: rtl/presc_count.sv
module presc_count #(
    parameter int LEN_W = 17
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_en,
    input  logic [LEN_W-1:0] len,
    output logic [LEN_W-1:0] cnt,
    output logic             sec_pulse
);
    logic [LEN_W-1:0] cnt_inc;
    assign cnt_inc = cnt + LEN_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt       <= '0;
            sec_pulse <= 1'b0;
        end else if (tick_en) begin
            if (cnt_inc >= len) begin
                cnt       <= '0;
                sec_pulse <= 1'b1;
            end else begin
                cnt       <= cnt_inc;
                sec_pulse <= 1'b0;
            end
        end else begin
            sec_pulse <= 1'b0;
        end
    end
endmodule

// File: rtl/sec_prescaler.sv
module sec_prescaler
    import rtc_presc_pkg::*;
#(
    parameter int REF_HZ = 32768
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_en,
    input  logic [5:0] min_in,
    input  logic [5:0] sec_in,
    input  logic       wr_en,
    input  logic [1:0] reg_addr,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    output logic       sec_pulse
);
    localparam int LEN_W = $clog2(REF_HZ + (1 << (TRIM_W-1))) + 1;

    presc_cfg_t       cfg;
    logic [LEN_W-1:0] len;
    logic [LEN_W-1:0] cnt;

    presc_regs u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .reg_addr(reg_addr),
        .wr_data(wr_data), .cfg(cfg), .rd_data(rd_data)
    );

    presc_len #(.REF_HZ(REF_HZ), .LEN_W(LEN_W)) u_len (
        .cfg(cfg), .min_in(min_in), .sec_in(sec_in), .len(len)
    );

    presc_count #(.LEN_W(LEN_W)) u_count (
        .clk(clk), .rst(rst), .tick_en(tick_en), .len(len),
        .cnt(cnt), .sec_pulse(sec_pulse)
    );
endmodule

// File: rtl/presc_checker.sv
module presc_checker #(
    parameter int LEN_W = 17
) (
    input logic             clk,
    input logic             rst,
    input logic             tick_en,
    input logic             wr_en,
    input logic [1:0]       reg_addr,
    input logic             sec_pulse,
    input logic [15:0]      trim,
    input logic             auto_en,
    input logic [LEN_W-1:0] cnt
);
    p_reset_quiet_r1: assert property (@(posedge clk) $past(rst) |-> !sec_pulse && trim == 16'h0 && !auto_en);

    p_pulse_needs_enable_r3: assert property (@(posedge clk) disable iff (rst) sec_pulse |-> $past(tick_en));

    p_idle_holds_count_r3: assert property (@(posedge clk) disable iff (rst) !tick_en |=> $stable(cnt));

    p_lo_write_keeps_hi_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && reg_addr == 2'd0) |=> trim[15:8] == $past(trim[15:8]));

    p_hi_write_keeps_lo_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && reg_addr == 2'd1) |=> trim[7:0] == $past(trim[7:0]));

    p_ctrl_only_by_write_r5: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && reg_addr == 2'd2) |=> $stable(auto_en));

    p_unused_addr_inert_r10: assert property (@(posedge clk) disable iff (rst)
        (wr_en && reg_addr == 2'd3) |=> $stable(trim) && $stable(auto_en));
endmodule

bind sec_prescaler presc_checker #(.LEN_W(LEN_W)) u_chk (
    .clk(clk), .rst(rst), .tick_en(tick_en), .wr_en(wr_en), .reg_addr(reg_addr),
    .sec_pulse(sec_pulse), .trim(cfg.trim), .auto_en(cfg.auto_en), .cnt(cnt)
);

// File: tb/test_sec_prescaler.sv
module test_sec_prescaler;
    localparam int REF = 64;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_en = 1'b0;
    logic [5:0] min_in = 6'd1;
    logic [5:0] sec_in = 6'd1;
    logic       wr_en = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       sec_pulse;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    sec_prescaler #(.REF_HZ(REF)) i_sec_prescaler (
        .clk(clk), .rst(rst), .tick_en(tick_en), .min_in(min_in), .sec_in(sec_in),
        .wr_en(wr_en), .reg_addr(reg_addr), .wr_data(wr_data),
        .rd_data(rd_data), .sec_pulse(sec_pulse)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            bad   = bad + 1;
            total = total + 1;
            $display("FAIL watchdog: actual=%0d cycles expected<=150000", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic write_reg(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; reg_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic read_check(input logic [1:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        reg_addr = a;
        #1;
        check(rd_data == exp, tag, rd_data, exp);
    endtask

    // Counts enables up to and including the one whose edge raises sec_pulse.
    task automatic measure(input int gap, output int n);
        n = 0;
        forever begin
            @(negedge clk);
            tick_en = 1'b1;
            @(posedge clk);
            n++;
            @(negedge clk);
            tick_en = 1'b0;
            if (sec_pulse || n > 100000) break;
            repeat (gap) @(negedge clk);
        end
    endtask

    task automatic set_trim(input logic [15:0] t, input logic auto);
        write_reg(2'd0, t[7:0]);
        write_reg(2'd1, t[15:8]);
        write_reg(2'd2, {5'd0, auto, 2'd0});
    endtask

    task automatic t_reset;
        check(sec_pulse == 1'b0, "R1 pulse low", sec_pulse, 0);
        read_check(2'd0, 8'h00, "R1 trim lo");
        read_check(2'd1, 8'h00, "R1 trim hi");
        read_check(2'd2, 8'h00, "R1 ctrl");
    endtask

    task automatic t_regs;
        write_reg(2'd0, 8'h9C);
        read_check(2'd0, 8'h9C, "R4 lo readback");
        read_check(2'd1, 8'h00, "R4 hi untouched");
        write_reg(2'd1, 8'hFF);
        read_check(2'd1, 8'hFF, "R4 hi readback");
        read_check(2'd0, 8'h9C, "R4 lo kept");
        write_reg(2'd2, 8'hFF);
        read_check(2'd2, 8'h04, "R5 ctrl only bit2");
        write_reg(2'd3, 8'h55);
        read_check(2'd3, 8'h00, "R10 unused reads 0");
        read_check(2'd0, 8'h9C, "R10 lo unchanged");
        read_check(2'd1, 8'hFF, "R10 hi unchanged");
        read_check(2'd2, 8'h04, "R10 ctrl unchanged");
        set_trim(16'h0000, 1'b0);
        read_check(2'd2, 8'h00, "R5 ctrl cleared");
    endtask

    task automatic t_nominal;
        int n;
        measure(0, n);
        check(n == REF, "R2 first second", n, REF);
        measure(0, n);
        check(n == REF, "R2 second period", n, REF);
        @(negedge clk); tick_en = 1'b1;
        @(posedge clk); #1;
        check(sec_pulse == 1'b0, "R2 one-cycle pulse", sec_pulse, 0);
        @(negedge clk); tick_en = 1'b0;
        measure(0, n);
        check(n == REF - 1, "R2 resync remainder", n, REF - 1);
    endtask

    task automatic t_sparse;
        int n;
        measure(2, n);
        check(n == REF, "R3 sparse enables", n, REF);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk); tick_en = 1'b1;
            @(negedge clk); tick_en = 1'b0;
        end
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (sec_pulse) check(1'b0, "R3 idle no pulse", 1, 0);
        end
        check(1'b1, "R3 idle window", 0, 0);
        measure(1, n);
        check(n == REF - 10, "R3 count kept over idle", n, REF - 10);
    endtask

    task automatic t_trim(input logic [15:0] t, input int exp, input string tag);
        int n;
        set_trim(t, 1'b1);
        min_in = 6'd0; sec_in = 6'd0;
        measure(0, n);
        check(n == exp, tag, n, exp);
        min_in = 6'd1; sec_in = 6'd1;
    endtask

    task automatic t_gate;
        int n;
        set_trim(16'hFFF2, 1'b0);
        min_in = 6'd0; sec_in = 6'd0;
        measure(0, n);
        check(n == REF, "R9 auto off", n, REF);
        write_reg(2'd2, 8'h04);
        min_in = 6'd5; sec_in = 6'd0;
        measure(0, n);
        check(n == REF, "R9 minutes nonzero", n, REF);
        min_in = 6'd0; sec_in = 6'd7;
        measure(0, n);
        check(n == REF, "R9 seconds nonzero", n, REF);
        min_in = 6'd0; sec_in = 6'd0;
        measure(0, n);
        check(n == REF - 14, "R9 gate open", n, REF - 14);
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_regs();
        t_nominal();
        t_sparse();
        t_trim(16'h0105, REF + 261, "R6 positive trim");
        measure(0, n);
        check(n == REF, "R6 next second nominal", n, REF);
        t_trim(16'hFFF2, REF - 14, "R7 negative trim");
        t_trim(16'hFF9C, 1, "R8 clamp first");
        min_in = 6'd0; sec_in = 6'd0;
        measure(0, n);
        check(n == 1, "R8 clamp repeat", n, 1);
        min_in = 6'd1; sec_in = 6'd1;
        t_gate();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule